// File: doc/BRIEF.md
# Slot Sync and Timing Selector

This block finds the start of a TDMA slot in a hard-decision bit stream and, in the same step, picks which of four sampling phases gives the cleanest symbols. The input carries one bit per clock. The bits of four sampling phases are interleaved in turn, so every fourth bit belongs to the same phase. On every clock the block takes the 32 most recent bits of the phase that has just advanced and compares them with a fixed slot header. It counts the mismatches in the whole header, in the 16-bit sync word and in the four preamble bits that come just before the sync word.

A phase qualifies when its sync-word mismatches and its preamble-tail mismatches are each within a run-time threshold. The first qualifying phase opens a window three candidates long. Inside that window, a qualifying phase with strictly fewer total mismatches takes its place. When the window closes, the block pulses a found flag, raises a lock flag and holds the chosen phase index. From then on it ignores the stream until a restart input starts a new search.

Top module: `slot_phase_sel`

## Requirements
- R1: After reset, and on the clock after `restart` is sampled high, `locked` and `slot_found` are 0 and `phase_sel` is 0.
- R2: No candidate is evaluated until 128 bits have been shifted in since the last restart or reset. A header that is complete before that point is never matched.
- R3: The header is 0xAAAAE98A, sent most significant bit first. Bit k of the header (k=0 is the last bit sent) is compared with the bit that arrived 4*k positions before the newest bit of the candidate. The bits are counted from 0, starting with the first bit after restart. The phase index of a candidate is the position of its newest bit modulo 4.
- R4: A candidate qualifies only when its mismatches in header bits 15..0 (the sync word) are at most `sync_thr` and its mismatches in header bits 19..16 (the last four preamble bits) are at most `tail_thr`.
- R5: The first qualifying candidate is stored with its total 32-bit mismatch count. Of the next three candidates, one that qualifies with a strictly lower total replaces the stored one. An equal total keeps the earlier candidate.
- R6: When the window closes, `slot_found` is high for exactly one cycle and `locked` rises with it. After that, `locked` and `phase_sel` stay unchanged until restart, whatever bits arrive.
- R7: `slot_found` goes high after the sixth rising edge that follows the edge which shifted in the newest bit of the first qualifying candidate.
- R8: `restart` clears a completed lock or a search in progress and starts the bit count again from position 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one stream bit per rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| restart | input | 1 | Synchronous re-arm: clears lock and history |
| bit_in | input | 1 | Hard-decision stream bit, phases interleaved |
| sync_thr | input | 5 | Largest sync-word mismatch count accepted |
| tail_thr | input | 3 | Largest preamble-tail mismatch count accepted |
| phase_sel | output | 2 | Chosen sampling phase index |
| slot_found | output | 1 | One-cycle pulse when the choice is final |
| locked | output | 1 | High from the choice until restart |

## Verification
The selection is tried on streams that are all zeros apart from the planted headers. In those streams the only possible winners are the planted ones, so the cases can single out first-wins, later-lower-wins and equal-total-keeps-first. One such stream has a second, perfect header placed after the lock; it shows whether the lock ignores later input. Other planted headers sit exactly on and just past each threshold, or end before the 128-bit fill is complete. These cases separate the two threshold comparisons and the fill gating. Random background streams with randomly corrupted headers in all four phases, and random thresholds, exercise the phase-index alignment and the fixed latency, because random noise can also qualify by chance.

// File: rtl/slot_sync_pkg.sv
package slot_sync_pkg;

   typedef enum logic [1:0] {
      ST_HUNT = 2'd0,
      ST_WIN  = 2'd1,
      ST_LOCK = 2'd2
   } pick_state_e;

   function automatic bit is_pow2(int v);
      return (v > 1) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/slot_tap_shift.sv
module slot_tap_shift #(
   parameter int PHASES   = 4,
   parameter int HDR_BITS = 32,
   parameter int PW       = $clog2(PHASES)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                restart,
   input  logic                bit_in,
   output logic [HDR_BITS-1:0] cand,
   output logic                cand_valid,
   output logic [PW-1:0]       cand_phase
);
   localparam int SR_LEN = PHASES * HDR_BITS;
   localparam int FILL_W = $clog2(SR_LEN + 1);

   logic [SR_LEN-1:0] hist_q;
   logic [FILL_W-1:0] fill_q;
   logic [PW-1:0]     pos_q;
   logic [PW-1:0]     head_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hist_q <= '0;
         fill_q <= '0;
         pos_q  <= '0;
         head_q <= '1;
      end else if (restart) begin
         hist_q <= '0;
         fill_q <= '0;
         pos_q  <= '0;
         head_q <= '1;
      end else begin
         hist_q <= {hist_q[SR_LEN-2:0], bit_in};
         if (fill_q != FILL_W'(SR_LEN))
            fill_q <= fill_q + FILL_W'(1);
         pos_q  <= pos_q + PW'(1);
         head_q <= pos_q;
      end
   end

   // one tap per header bit, stepping over the other phases
   for (genvar k = 0; k < HDR_BITS; k++) begin : g_tap
      assign cand[k] = hist_q[k*PHASES];
   end

   assign cand_valid = (fill_q == FILL_W'(SR_LEN));
   assign cand_phase = head_q;

   // R2: history must refill after a restart
   a_r2_refill: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> !cand_valid);

   // R3: phase index steps by one per accepted bit
   a_r3_phase_step: assert property (@(posedge clk) disable iff (!rst_n)
      !restart |=> cand_phase == $past(cand_phase) + PW'(1));

endmodule

// File: rtl/slot_err_pipe.sv
module slot_err_pipe #(
   parameter int          HDR_BITS  = 32,
   parameter int          SYNC_BITS = 16,
   parameter int          TAIL_BITS = 4,
   parameter logic [HDR_BITS-1:0] PATTERN = 32'hAAAAE98A,
   parameter int          PW        = 2,
   parameter int          SYNC_W    = $clog2(SYNC_BITS + 1),
   parameter int          TAIL_W    = $clog2(TAIL_BITS + 1),
   parameter int          TOT_W     = $clog2(HDR_BITS + 1)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                restart,
   input  logic [HDR_BITS-1:0] cand,
   input  logic                cand_valid,
   input  logic [PW-1:0]       cand_phase,
   input  logic [SYNC_W-1:0]   sync_thr,
   input  logic [TAIL_W-1:0]   tail_thr,
   output logic                q_valid,
   output logic [TOT_W-1:0]    q_total,
   output logic [PW-1:0]       q_phase
);
   localparam int SUM_W = TOT_W + 1;

   logic [HDR_BITS-1:0] miss;
   logic [TOT_W-1:0]    c_tot;
   logic [SYNC_W-1:0]   c_sync;
   logic [TAIL_W-1:0]   c_tail;

   logic                s1_valid;
   logic [TOT_W-1:0]    s1_tot;
   logic [SYNC_W-1:0]   s1_sync;
   logic [TAIL_W-1:0]   s1_tail;
   logic [PW-1:0]       s1_phase;

   assign miss = cand ^ PATTERN;

   always_comb begin
      c_tot  = '0;
      c_sync = '0;
      c_tail = '0;
      for (int i = 0; i < HDR_BITS; i++) begin
         c_tot = c_tot + TOT_W'(miss[i]);
         if (i < SYNC_BITS)
            c_sync = c_sync + SYNC_W'(miss[i]);
         else if (i < SYNC_BITS + TAIL_BITS)
            c_tail = c_tail + TAIL_W'(miss[i]);
      end
   end

   // stage 1: mismatch counts
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1_valid <= 1'b0;
         s1_tot   <= '0;
         s1_sync  <= '0;
         s1_tail  <= '0;
         s1_phase <= '0;
      end else begin
         s1_valid <= cand_valid && !restart;
         s1_tot   <= c_tot;
         s1_sync  <= c_sync;
         s1_tail  <= c_tail;
         s1_phase <= cand_phase;
      end
   end

   // stage 2: threshold decision
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q_valid <= 1'b0;
         q_total <= '0;
         q_phase <= '0;
      end else begin
         q_valid <= s1_valid && !restart &&
                    (s1_sync <= sync_thr) && (s1_tail <= tail_thr);
         q_total <= s1_tot;
         q_phase <= s1_phase;
      end
   end

   // R4: the partial counts never exceed the total
   a_r4_split: assert property (@(posedge clk) disable iff (!rst_n)
      s1_valid |-> SUM_W'(s1_tot) >= SUM_W'(s1_sync) + SUM_W'(s1_tail));

   // R2: nothing qualifies on the clock after a restart
   a_r2_flush: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> !q_valid);

endmodule

// File: rtl/slot_pick.sv
module slot_pick
   import slot_sync_pkg::*;
#(
   parameter int PW      = 2,
   parameter int TOT_W   = 6,
   parameter int WIN_LEN = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             restart,
   input  logic             q_valid,
   input  logic [TOT_W-1:0] q_total,
   input  logic [PW-1:0]    q_phase,
   output logic [PW-1:0]    phase_sel,
   output logic             slot_found,
   output logic             locked
);
   localparam int CNT_W = $clog2(WIN_LEN + 1);

   pick_state_e      st_q;
   logic [TOT_W-1:0] best_q;
   logic [PW-1:0]    bphase_q;
   logic [CNT_W-1:0] left_q;
   logic             found_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q     <= ST_HUNT;
         best_q   <= '0;
         bphase_q <= '0;
         left_q   <= '0;
         found_q  <= 1'b0;
      end else begin
         found_q <= 1'b0;
         if (restart) begin
            st_q     <= ST_HUNT;
            best_q   <= '0;
            bphase_q <= '0;
            left_q   <= '0;
         end else begin
            case (st_q)
               ST_HUNT: if (q_valid) begin
                  best_q   <= q_total;
                  bphase_q <= q_phase;
                  left_q   <= CNT_W'(WIN_LEN);
                  st_q     <= ST_WIN;
               end
               ST_WIN: begin
                  if (q_valid && (q_total < best_q)) begin
                     best_q   <= q_total;
                     bphase_q <= q_phase;
                  end
                  left_q <= left_q - CNT_W'(1);
                  if (left_q == CNT_W'(1)) begin
                     st_q    <= ST_LOCK;
                     found_q <= 1'b1;
                  end
               end
               default: ;
            endcase
         end
      end
   end

   assign phase_sel  = bphase_q;
   assign slot_found = found_q;
   assign locked     = (st_q == ST_LOCK);

   // R1 / R8: restart drops the lock
   a_r1_restart_clear: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> (!locked && !slot_found));

   // R6: found is a single-cycle pulse
   a_r6_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      slot_found |=> !slot_found);

   // R6: found only coincides with a lock
   a_r6_found_locked: assert property (@(posedge clk) disable iff (!rst_n)
      slot_found |-> locked);

   // R6: the lock and its phase hold until restart
   a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (locked && !restart) |=> (locked && $stable(phase_sel)));

   // R5: the stored total never grows inside the window
   a_r5_no_worse: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_WIN && $past(st_q == ST_WIN)) |-> best_q <= $past(best_q));

endmodule

// File: rtl/slot_phase_sel.sv
module slot_phase_sel
   import slot_sync_pkg::*;
#(
   parameter int PHASES    = 4,
   parameter int HDR_BITS  = 32,
   parameter int SYNC_BITS = 16,
   parameter int TAIL_BITS = 4,
   parameter logic [HDR_BITS-1:0] HDR_PATTERN = 32'hAAAAE98A,
   parameter int WIN_LEN   = 3,
   localparam int PW       = $clog2(PHASES),
   localparam int SYNC_W   = $clog2(SYNC_BITS + 1),
   localparam int TAIL_W   = $clog2(TAIL_BITS + 1),
   localparam int TOT_W    = $clog2(HDR_BITS + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              restart,
   input  logic              bit_in,
   input  logic [SYNC_W-1:0] sync_thr,
   input  logic [TAIL_W-1:0] tail_thr,
   output logic [PW-1:0]     phase_sel,
   output logic              slot_found,
   output logic              locked
);
   // elaboration-time parameter checks
   if (!is_pow2(PHASES)) begin : g_bad_phases
      $error("PHASES must be a power of two of at least 2");
   end
   if (SYNC_BITS + TAIL_BITS > HDR_BITS) begin : g_bad_fields
      $error("sync and tail fields exceed the header");
   end
   if (WIN_LEN < 1) begin : g_bad_window
      $error("WIN_LEN must be at least 1");
   end

   logic [HDR_BITS-1:0] cand;
   logic                cand_valid;
   logic [PW-1:0]       cand_phase;
   logic                q_valid;
   logic [TOT_W-1:0]    q_total;
   logic [PW-1:0]       q_phase;

   slot_tap_shift #(
      .PHASES   (PHASES),
      .HDR_BITS (HDR_BITS),
      .PW       (PW)
   ) u_taps (
      .clk        (clk),
      .rst_n      (rst_n),
      .restart    (restart),
      .bit_in     (bit_in),
      .cand       (cand),
      .cand_valid (cand_valid),
      .cand_phase (cand_phase)
   );

   slot_err_pipe #(
      .HDR_BITS  (HDR_BITS),
      .SYNC_BITS (SYNC_BITS),
      .TAIL_BITS (TAIL_BITS),
      .PATTERN   (HDR_PATTERN),
      .PW        (PW),
      .SYNC_W    (SYNC_W),
      .TAIL_W    (TAIL_W),
      .TOT_W     (TOT_W)
   ) u_errs (
      .clk        (clk),
      .rst_n      (rst_n),
      .restart    (restart),
      .cand       (cand),
      .cand_valid (cand_valid),
      .cand_phase (cand_phase),
      .sync_thr   (sync_thr),
      .tail_thr   (tail_thr),
      .q_valid    (q_valid),
      .q_total    (q_total),
      .q_phase    (q_phase)
   );

   slot_pick #(
      .PW      (PW),
      .TOT_W   (TOT_W),
      .WIN_LEN (WIN_LEN)
   ) u_pick (
      .clk        (clk),
      .rst_n      (rst_n),
      .restart    (restart),
      .q_valid    (q_valid),
      .q_total    (q_total),
      .q_phase    (q_phase),
      .phase_sel  (phase_sel),
      .slot_found (slot_found),
      .locked     (locked)
   );

endmodule

// File: tb/slot_phase_sel_bench.sv
module slot_phase_sel_bench;
   localparam int LA  = 420;
   localparam int TOT = 436;
   localparam logic [31:0] PAT = 32'hAAAAE98A;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       restart = 1'b0;
   logic       bit_in = 1'b0;
   logic [4:0] sync_thr = '0;
   logic [2:0] tail_thr = '0;
   logic [1:0] phase_sel;
   logic       slot_found;
   logic       locked;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;
   bit s [TOT];
   int cur_s, cur_t;

   always #5 clk = ~clk;

   slot_phase_sel u_slot_phase_sel (
      .clk        (clk),
      .rst_n      (rst_n),
      .restart    (restart),
      .bit_in     (bit_in),
      .sync_thr   (sync_thr),
      .tail_thr   (tail_thr),
      .phase_sel  (phase_sel),
      .slot_found (slot_found),
      .locked     (locked)
   );

   task automatic chk(bit ok, string what, int act, int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s act=%0d exp=%0d", what, act, exp);
      end
   endtask

   task automatic fill_zero();
      for (int i = 0; i < TOT; i++) s[i] = 1'b0;
   endtask

   task automatic fill_rand();
      for (int i = 0; i < TOT; i++) s[i] = (i < LA) ? 1'($urandom_range(0, 1)) : 1'b0;
   endtask

   // header starting at stream position st; flips in sync, tail and early preamble
   task automatic plant(int st, int fs, int ft, int fp);
      for (int k = 0; k < 32; k++) s[st + 4*(31-k)] = PAT[k];
      for (int j = 0; j < fs; j++) s[st + 4*(31-j)]      = ~PAT[j];
      for (int j = 0; j < ft; j++) s[st + 4*(15-j)]      = ~PAT[16+j];
      for (int j = 0; j < fp; j++) s[st + 4*(11-j)]      = ~PAT[20+j];
   endtask

   // R4: total mismatches if the candidate ending at n qualifies, else -1
   function automatic int qual(int n);
      int se = 0, te = 0, to = 0;
      for (int k = 0; k < 32; k++) begin
         int b;
         b = int'(s[n - 4*k] ^ PAT[k]);
         to += b;
         if (k < 16) se += b;
         else if (k < 20) te += b;
      end
      return (se <= cur_s && te <= cur_t) ? to : -1;
   endfunction

   task automatic model(output bit ef, output int eedge, output int eph);
      int n0 = -1;
      int best, bn;
      ef = 1'b0; eedge = -1; eph = 0;
      for (int n = 127; n < TOT; n++) begin
         if (qual(n) >= 0) begin n0 = n; break; end
      end
      if (n0 >= 0 && n0 + 6 <= TOT - 1) begin
         best = qual(n0); bn = n0;
         for (int j = 1; j <= 3; j++) begin
            int t;
            t = qual(n0 + j);
            if (t >= 0 && t < best) begin best = t; bn = n0 + j; end
         end
         ef = 1'b1; eedge = n0 + 6; eph = bn % 4;
      end
   endtask

   // restart must already be high at entry (set at a falling edge)
   task automatic run_case(string tag, int st, int tt);
      bit ef; int eedge, eph;
      int pulses = 0, fe = -1, ph = 0;
      sync_thr = 5'(st); tail_thr = 3'(tt); cur_s = st; cur_t = tt;
      model(ef, eedge, eph);
      @(negedge clk);
      chk(!locked && !slot_found && phase_sel == 0, "R1 R8 cleared after restart",
          int'(locked) + int'(slot_found) + int'(phase_sel), 0);
      restart = 1'b0;
      bit_in = s[0];
      for (int n = 1; n <= TOT; n++) begin
         @(negedge clk);
         if (slot_found) begin
            pulses++;
            if (fe < 0) begin fe = n - 1; ph = int'(phase_sel); end
         end
         if (n < TOT) bit_in = s[n];
      end
      restart = 1'b1;
      bit_in = 1'b0;
      chk(pulses == int'(ef), {tag, " R6 pulse count"}, pulses, int'(ef));
      chk(locked == ef, {tag, " R6 lock level"}, int'(locked), int'(ef));
      if (ef) begin
         chk(fe == eedge, {tag, " R7 found edge"}, fe, eedge);
         chk(ph == eph, {tag, " R3 chosen phase"}, ph, eph);
         chk(int'(phase_sel) == ph, {tag, " R6 phase held"}, int'(phase_sel), ph);
      end else begin
         chk(phase_sel == 0, {tag, " R2 R4 no choice"}, int'(phase_sel), 0);
      end
   endtask

   initial begin
      void'($urandom(32'd20250611));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!locked && !slot_found && phase_sel == 0, "R1 reset state",
          int'(locked) + int'(slot_found) + int'(phase_sel), 0);
      restart = 1'b1;

      // R5 R6: perfect first candidate, worse neighbours, later header ignored
      fill_zero(); plant(140, 0, 0, 0); plant(141, 1, 0, 2); plant(142, 0, 0, 1);
      plant(143, 2, 1, 0); plant(272, 0, 0, 0);
      run_case("R5 first-best", 2, 1);

      // R5: a later, lower total replaces the first
      fill_zero(); plant(141, 0, 0, 3); plant(142, 0, 0, 1); plant(143, 0, 0, 0);
      run_case("R5 lower-replaces", 2, 1);

      // R5: equal totals keep the earliest
      fill_zero(); plant(142, 0, 0, 2); plant(143, 0, 0, 2); plant(144, 0, 0, 2);
      run_case("R5 tie-keeps-first", 2, 1);

      // R4: one over sync limit, exactly at both limits, one over tail limit
      fill_zero(); plant(150, 4, 0, 0); plant(151, 3, 1, 0); plant(152, 0, 2, 0);
      run_case("R4 threshold-edge", 3, 1);

      // R2: header complete before the history is full
      fill_zero(); plant(0, 0, 0, 0);
      run_case("R2 before-fill", 4, 2);

      // R3: clean header, zero thresholds
      fill_zero(); plant(201, 0, 0, 0);
      run_case("R3 exact-zero-thr", 0, 0);

      // R4: no header at all
      fill_zero();
      run_case("R4 no-header", 4, 2);

      // R3 R7: random background, corrupted headers in all phases
      for (int r = 0; r < 10; r++) begin
         int st;
         fill_rand();
         st = 130 + int'($urandom_range(0, 79));
         for (int o = 0; o < 4; o++)
            plant(st + o, int'($urandom_range(0, 4)), int'($urandom_range(0, 1)),
                  int'($urandom_range(0, 3)));
         run_case("R3 random", int'($urandom_range(0, 4)), int'($urandom_range(0, 2)));
      end

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #(200000 * 10);
      if (!done) begin
         errors++;
         $display("FAIL watchdog R6 act=hung exp=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule